// File: doc/BRIEF.md
# Flash Section Lock Guard

This unit sits between the processor's self-programming path and the program flash array. It holds four sticky lock bits and, for every flash access, decides at once whether the access may proceed. Two kinds of access are judged: stores that modify flash, and program-memory reads. The flash space is split into two sections by word address. The application section covers 0x0000 up to and including 0x1DFF. The boot section covers 0x1E00 up to and including 0x1FFF. The caller supplies the target word address, whether the access is a store, and which section the program counter is currently executing from. The unit answers with a single grant bit.

Each section has its own pair of lock bits. A bit reads 1 when unprogrammed and 0 when programmed. The two bits of a pair work on their own. The low bit of a pair bars stores into that section. The high bit bars reads of that section by code that runs in the other section. Reads from inside the section itself are always allowed. A lock update can only program bits, never clear them. Only a chip-erase input brings all four bits back to 1. The unit also produces the reset vector from the boot-reset fuse input.

The pair settings are handled as an enumerated mode with four named values:
- `MODE_OPEN` (11)
- `MODE_NO_STORE` (10)
- `MODE_LOCKED` (00)
- `MODE_NO_XREAD` (01)

The lock register has no sequencing states. Its only transitions are:
- hold;
- program-by-AND on an update;
- restore-all-ones on erase.

Top module: `lbp_guard`

## Requirements
- R1: After reset all four lock bits are 1 (unprogrammed), so every access is granted.
- R2: A target word address below 0x1E00 belongs to the application section. Addresses 0x1E00 and above belong to the boot section. The guarding pair is `lock_data_i[1:0]` for the application section and `lock_data_i[3:2]` for the boot section.
- R3: With the target section's pair at 11, stores and reads of that section are granted.
- R4: With the pair at 10, stores to that section are denied and all reads of it are granted.
- R5: With the pair at 00, stores to that section are denied. Reads of it are denied when the program counter is in the other section.
- R6: With the pair at 01, stores to that section are granted. Reads of it are denied when the program counter is in the other section.
- R7: A read whose target lies in the same section as the program counter is granted whatever the lock bits hold.
- R8: A lock update stores the bitwise AND of the old bits and `lock_data_i`. A bit at 0 never returns to 1 through an update.
- R9: A chip erase sets all four lock bits to 1 at the next edge. Erase takes priority over an update in the same cycle.
- R10: `grant_o` is combinational from the current lock bits and the request. A lock update or erase changes grants from the following cycle on, not in the cycle it is applied.
- R11: `reset_vec_o` is 0x1E00 when `boot_fuse_i` is 0 and 0x0000 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; lock bits return to all ones |
| erase_i | input | 1 | Chip erase: restore all lock bits to 1 |
| lock_wr_i | input | 1 | Lock update strobe from the self-programming path |
| lock_data_i | input | 4 | Update value; [3:2] boot pair (read, store), [1:0] application pair (read, store) |
| acc_store_i | input | 1 | 1 = store access, 0 = program-memory read |
| acc_addr_i | input | 13 | Target word address |
| pc_in_boot_i | input | 1 | 1 when the program counter is in the boot section |
| boot_fuse_i | input | 1 | Boot-reset fuse (0 = programmed) |
| grant_o | output | 1 | 1 = access allowed |
| reset_vec_o | output | 13 | Reset vector word address |

## Verification
The unit's only state is the four lock bits, and every one of them can be seen at the ports. A stored bit that is wrong flips `grant_o` for a store or a cross-section read of its section in the very same cycle it is probed. The bench's reference model therefore compares the grant on every cycle against a model that tracks the lock bits on its own. Any bit that was not programmed, that was restored by an update, or that a missed erase left behind shows up as a mismatch within one probing cycle. Sweeps across the section boundary addresses also expose a section decode that is off by one.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

    // Setting of one lock pair, written as {read_guard, store_guard}.
    typedef enum logic [1:0] {
        MODE_LOCKED   = 2'b00,
        MODE_NO_XREAD = 2'b01,
        MODE_NO_STORE = 2'b10,
        MODE_OPEN     = 2'b11
    } guard_mode_e;

    typedef struct packed {
        logic store_ok;
        logic xread_ok;
    } perm_t;

    localparam int unsigned NUM_SECT = 2;
    localparam int unsigned LOCK_W   = 2 * NUM_SECT;

endpackage

// File: rtl/lbp_lock_store.sv
module lbp_lock_store
    import lbp_pkg::*;
#(
    parameter int unsigned LW = LOCK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_i,
    input  logic          upd_i,
    input  logic [LW-1:0] upd_data_i,
    output logic [LW-1:0] lock_o
);

    logic [LW-1:0] lock_q;
    logic [LW-1:0] lock_d;

    always_comb begin
        lock_d = lock_q;
        if (erase_i) begin
            lock_d = '1;
        end else if (upd_i) begin
            lock_d = lock_q & upd_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '1;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/lbp_addr_decode.sv
module lbp_addr_decode #(
    parameter int unsigned         ADDR_W    = 13,
    parameter logic [ADDR_W-1:0]   BOOT_BASE = 13'h1E00
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_boot_o
);

    assign in_boot_o = (addr_i >= BOOT_BASE);

endmodule

// File: rtl/lbp_section_rule.sv
module lbp_section_rule
    import lbp_pkg::*;
(
    input  logic [1:0] pair_i,
    output perm_t      perm_o
);

    guard_mode_e mode;

    assign mode = guard_mode_e'(pair_i);

    always_comb begin
        perm_o = '0;
        unique case (mode)
            MODE_OPEN:     perm_o = '{store_ok: 1'b1, xread_ok: 1'b1};
            MODE_NO_STORE: perm_o = '{store_ok: 1'b0, xread_ok: 1'b1};
            MODE_LOCKED:   perm_o = '{store_ok: 1'b0, xread_ok: 1'b0};
            MODE_NO_XREAD: perm_o = '{store_ok: 1'b1, xread_ok: 1'b0};
            default:       perm_o = '0;
        endcase
    end

endmodule

// File: rtl/lbp_guard.sv
module lbp_guard
    import lbp_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 13'h1E00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              lock_wr_i,
    input  logic [LOCK_W-1:0] lock_data_i,
    input  logic              acc_store_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              pc_in_boot_i,
    input  logic              boot_fuse_i,
    output logic              grant_o,
    output logic [ADDR_W-1:0] reset_vec_o
);

    logic [LOCK_W-1:0] lock_q;
    logic              tgt_boot;
    perm_t             perm [NUM_SECT];
    perm_t             sel;

    lbp_lock_store #(.LW(LOCK_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_i    (erase_i),
        .upd_i      (lock_wr_i),
        .upd_data_i (lock_data_i),
        .lock_o     (lock_q)
    );

    lbp_addr_decode #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_dec (
        .addr_i    (acc_addr_i),
        .in_boot_o (tgt_boot)
    );

    // Section 0 = application, section 1 = boot.
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_rule
        lbp_section_rule u_rule (
            .pair_i (lock_q[2*g+1 -: 2]),
            .perm_o (perm[g])
        );
    end

    assign sel = tgt_boot ? perm[1] : perm[0];

    always_comb begin
        if (acc_store_i) begin
            grant_o = sel.store_ok;
        end else if (pc_in_boot_i == tgt_boot) begin
            grant_o = 1'b1;
        end else begin
            grant_o = sel.xread_ok;
        end
    end

    assign reset_vec_o = boot_fuse_i ? '0 : BOOT_BASE;

endmodule

// File: rtl/lbp_guard_chk.sv
module lbp_guard_chk #(
    parameter int unsigned       ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 13'h1E00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              erase_i,
    input logic              lock_wr_i,
    input logic [3:0]        lock_data_i,
    input logic              acc_store_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              pc_in_boot_i,
    input logic              boot_fuse_i,
    input logic              grant_o,
    input logic [ADDR_W-1:0] reset_vec_o,
    input logic [3:0]        lock_q
);

    // R8
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_i |=> ((lock_q & ~$past(lock_q)) == 4'h0));

    // R8
    and_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr_i && !erase_i) |=> (lock_q == ($past(lock_q) & $past(lock_data_i))));

    // R9
    erase_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (lock_q == 4'hF));

    // R7
    same_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_store_i && (pc_in_boot_i == (acc_addr_i >= BOOT_BASE))) |-> grant_o);

    // R4
    boot_store_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_store_i && (acc_addr_i >= BOOT_BASE) && !lock_q[2]) |-> !grant_o);

    // R11
    reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_vec_o == (boot_fuse_i ? '0 : BOOT_BASE));

endmodule

bind lbp_guard lbp_guard_chk #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .erase_i      (erase_i),
    .lock_wr_i    (lock_wr_i),
    .lock_data_i  (lock_data_i),
    .acc_store_i  (acc_store_i),
    .acc_addr_i   (acc_addr_i),
    .pc_in_boot_i (pc_in_boot_i),
    .boot_fuse_i  (boot_fuse_i),
    .grant_o      (grant_o),
    .reset_vec_o  (reset_vec_o),
    .lock_q       (lock_q)
);

// File: tb/lbp_guard_tb.sv
module lbp_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        erase_i = 1'b0;
    logic        lock_wr_i = 1'b0;
    logic [3:0]  lock_data_i = 4'hF;
    logic        acc_store_i = 1'b0;
    logic [12:0] acc_addr_i = '0;
    logic        pc_in_boot_i = 1'b0;
    logic        boot_fuse_i = 1'b1;
    logic        grant_o;
    logic [12:0] reset_vec_o;

    int checks = 0;
    int failures = 0;
    int ref_lock = 15;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lbp_guard u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .erase_i      (erase_i),
        .lock_wr_i    (lock_wr_i),
        .lock_data_i  (lock_data_i),
        .acc_store_i  (acc_store_i),
        .acc_addr_i   (acc_addr_i),
        .pc_in_boot_i (pc_in_boot_i),
        .boot_fuse_i  (boot_fuse_i),
        .grant_o      (grant_o),
        .reset_vec_o  (reset_vec_o)
    );

    // Behavioural expectation straight from the requirements.
    function automatic bit exp_grant(int lk, bit st, int addr, bit pcb);
        bit tb;
        int pair;
        tb   = (addr >= 'h1E00);
        pair = tb ? ((lk >> 2) & 3) : (lk & 3);
        if (st) return pair[0];
        if (pcb == tb) return 1'b1;
        return pair[1];
    endfunction

    task automatic check(string tag, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: grant=%0b expected=%0b lock=%h st=%0b addr=%h pcb=%0b",
                     tag, got, exp, ref_lock[3:0], acc_store_i, acc_addr_i, pc_in_boot_i);
        end
    endtask

    // One clock: drive at negedge, compare at +1, update model at posedge.
    task automatic step(string tag, bit er, bit wr, int data, bit st, int addr, bit pcb);
        @(negedge clk);
        erase_i = er; lock_wr_i = wr; lock_data_i = data[3:0];
        acc_store_i = st; acc_addr_i = addr[12:0]; pc_in_boot_i = pcb;
        #1;
        if (!st && (pcb == (addr >= 'h1E00)))
            check("R7", grant_o, exp_grant(ref_lock, st, addr, pcb));
        else
            check(tag, grant_o, exp_grant(ref_lock, st, addr, pcb));
        @(posedge clk);
        if (er) ref_lock = 15;
        else if (wr) ref_lock = ref_lock & data;
    endtask

    task automatic sweep(string tag);
        int addrs [4] = '{'h0000, 'h1DFF, 'h1E00, 'h1FFF};
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 2; p++)
                    step((a == 1 || a == 2) ? {tag, "/R2"} : tag, 0, 0, 15, s[0], addrs[a], p[0]);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lfsr = 32'h1ACE;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R11 reset vector
        @(negedge clk); boot_fuse_i = 1'b1; #1;
        checks++;
        if (reset_vec_o !== 13'h0000) begin failures++; $display("FAIL R11: vec=%h expected=0000", reset_vec_o); end
        boot_fuse_i = 1'b0; #1;
        checks++;
        if (reset_vec_o !== 13'h1E00) begin failures++; $display("FAIL R11: vec=%h expected=1E00", reset_vec_o); end
        boot_fuse_i = 1'b1;

        sweep("R1/R3");
        // Program application store guard; R10: same-cycle store still granted.
        step("R10", 0, 1, 4'b1110, 1, 'h0100, 1);
        sweep("R4");
        // Attempt to restore bits via update: no effect (R8).
        step("R8", 0, 1, 4'b1111, 1, 'h0100, 1);
        step("R8", 0, 0, 15, 1, 'h0100, 1);
        // Program application read guard: pair 00.
        step("R8", 0, 1, 4'b1101, 0, 'h0200, 1);
        sweep("R5");
        // Erase wins over a same-cycle update (R9); R10 old value still seen.
        step("R10", 1, 1, 4'b0000, 1, 'h0010, 0);
        sweep("R9");
        // Boot pair 01.
        step("R8", 0, 1, 4'b0111, 0, 'h1F00, 0);
        sweep("R6");
        step("R9", 1, 0, 15, 0, 'h1F00, 0);
        // Boot pair 00 plus app 10.
        step("R8", 0, 1, 4'b0010, 1, 'h1F00, 0);
        sweep("R5");
        // Pseudo-random traffic.
        for (int i = 0; i < 300; i++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
            step("R8", (lfsr[7:0] == 8'h11), (lfsr[3:1] == 3'b101), lfsr[15:12],
                 lfsr[4], lfsr[28:16], lfsr[5]);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule